// File: doc/BRIEF.md
# Serial Status Flag Arm-and-Clear Logic

This block holds the nine status flags of a UART-style serial port and the rule that clears them. Transmitter and receiver hardware raise flags through one-cycle set pulses. Software clears a flag in two steps. First it reads the status register while the flag is set, which arms that flag. Then it accesses the data register in the direction that suits the flag. Receive-side flags clear on a data read. The two transmit flags clear on a data write.

A flag that rises after the arming read is not armed, so the later data access does not clear it. A single 32-bit read returns status and data together. That read arms and clears every receive flag set at that moment, and leaves the transmit flags set. The block also drives the receive and idle interrupt requests.

The bus side is a single-cycle slave that is always ready. Read data is combinational in the cycle of the access, and a flag changes on the clock edge that ends the access. The shifters, baud timing and wakeup logic sit outside this block. Data-register writes are passed to the transmitter as a strobe with the written character. Data-register reads return the character currently presented by the receiver.

Top module: `ser_status_arm`

## Requirements
- R1: After reset, TDRE (bit 8) and TC (bit 7) of `flags` are 1. RDRF (bit 6), RAF (bit 5), IDLE (bit 4), OR (bit 3), NF (bit 2), FE (bit 1) and PF (bit 0) are 0, no flag is armed, and both interrupt requests are low.
- R2: A one-cycle pulse on `set_pulse[i]` makes flag i read 1 after that clock edge. Writes to status offsets 0 or 1 change no flag, whatever data they carry.
- R3: A receive flag (bits 6..0) that a status read saw set clears on a later data read. A data read is a byte read at offset 3 or 2 (size 0), or a half-word read at offset 2 (size 1). Offsets are byte addresses in a 32-bit big-endian view with status at 0..1 and data at 2..3.
- R4: TDRE and TC, once armed, clear only on a data write: a byte write at offset 3 or a half-word write at offset 2. Data reads and a byte write to offset 2 leave them set.
- R5: A flag set after the status read, and before the data access, stays set through that access. It clears after a fresh status read and data access.
- R6: A status read arms every flag set at that moment. This holds for a byte read at offset 0 (upper), a byte read at offset 1 (lower) or a half-word read at offset 0.
- R7: A word read (size 2, offset 0) returns `{7'b0, flags}` in bits 31:16 and the receive data in bits 15:0. It clears every receive flag set in that cycle, and leaves TDRE and TC unchanged.
- R8: When a set pulse and a clear for the same flag fall in one cycle, the flag stays 1 and is disarmed. A further data access alone does not clear it.
- R9: `tdre_hw_clr` clears TDRE and disarms it. If TDRE is then set again, a data write does not clear it until TDRE is re-armed by a new status read.
- R10: `rx_irq` is high exactly when `rx_irq_en` is high and RDRF or OR is set. `idle_irq` is high exactly when `idle_irq_en` is high and IDLE is set.
- R11: A data write drives `tx_wr_stb` high in the same cycle, with `tx_wr_data` set to the written character (bits 8:0 for a half-word, bits 7:0 for a byte). A data read returns `rx_data_in` in bits 8:0 of `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset: 0..1 status, 2..3 data |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 16 | Write data, byte at offset 3 on bits 7:0 |
| bus_rdata | output | 32 | Status in 31:16, data in 15:0 |
| rx_data_in | input | 9 | Character presented by the receiver |
| tx_wr_stb | output | 1 | Data-register write strobe to the transmitter |
| tx_wr_data | output | 9 | Character written |
| set_pulse | input | 9 | Per-flag hardware set pulses, bit order as in R1 |
| tdre_hw_clr | input | 1 | Transmitter loaded new data, clears TDRE |
| rx_irq_en | input | 1 | Receive interrupt enable |
| idle_irq_en | input | 1 | Idle interrupt enable |
| flags | output | 9 | Current flag values |
| rx_irq | output | 1 | Receive interrupt request |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
The hardest case to reach from the ports is a set pulse that meets a clear in the same cycle. The flag's visible value does not change in that case. Only the dropped arm bit shows the difference, and it shows only on the next data access. The bench drives the set pulse inside the same task call that issues the data read. It then makes a second bare data read and checks that the flag survives. The same indirect method covers the disarm caused by a hardware TDRE clear. TDRE is cleared, set again, and then given a data write that clears only the still-armed TC.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int unsigned NUM_FLAGS = 9;
  localparam int unsigned SR_WIDTH  = 16;
  localparam int unsigned CHAR_W    = 9;

  localparam int unsigned F_PF   = 0;
  localparam int unsigned F_FE   = 1;
  localparam int unsigned F_NF   = 2;
  localparam int unsigned F_OR   = 3;
  localparam int unsigned F_IDLE = 4;
  localparam int unsigned F_RAF  = 5;
  localparam int unsigned F_RDRF = 6;
  localparam int unsigned F_TC   = 7;
  localparam int unsigned F_TDRE = 8;

  localparam logic [NUM_FLAGS-1:0] TX_MASK  = 9'h180;
  localparam logic [NUM_FLAGS-1:0] RST_VAL  = 9'h180;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic stat_rd;
    logic dat_rd;
    logic dat_wr;
    logic word_rd;
  } acc_dec_t;
endpackage

// File: rtl/ser_bus_decode.sv
module ser_bus_decode
  import ser_stat_pkg::*;
(
  input  logic           en,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [1:0]     size,
  output acc_dec_t       dec
);
  logic is_byte, is_half, is_word;

  always_comb begin
    is_byte = (size == SZ_BYTE);
    is_half = (size == SZ_HALF);
    is_word = (size == SZ_WORD);

    dec.word_rd = en && !we && is_word && (addr == 2'd0);
    dec.stat_rd = en && !we && !addr[1] &&
                  (is_byte || ((is_half || is_word) && (addr == 2'd0)));
    dec.dat_rd  = dec.word_rd ||
                  (en && !we && addr[1] &&
                   (is_byte || (is_half && (addr == 2'd2))));
    dec.dat_wr  = en && we &&
                  ((is_byte && (addr == 2'd3)) || (is_half && (addr == 2'd2)));
  end
endmodule

// File: rtl/ser_flag_cell.sv
module ser_flag_cell #(
  parameter bit IS_TX   = 1'b0,
  parameter bit RST_ONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic stat_rd_i,
  input  logic dat_rd_i,
  input  logic dat_wr_i,
  input  logic word_rd_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic clr_req;

  always_comb begin
    if (IS_TX) clr_req = arm_q && dat_wr_i;
    else       clr_req = (arm_q || (word_rd_i && flag_q)) && dat_rd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_ONE;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                    flag_q <= 1'b1;
      else if (clr_req || hw_clr_i) flag_q <= 1'b0;

      if (clr_req || hw_clr_i)      arm_q <= 1'b0;
      else if (stat_rd_i)           arm_q <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ser_status_arm.sv
module ser_status_arm
  import ser_stat_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS,
  parameter int unsigned CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [15:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [CW-1:0] rx_data_in,
  output logic          tx_wr_stb,
  output logic [CW-1:0] tx_wr_data,
  input  logic [NF-1:0] set_pulse,
  input  logic          tdre_hw_clr,
  input  logic          rx_irq_en,
  input  logic          idle_irq_en,
  output logic [NF-1:0] flags,
  output logic          rx_irq,
  output logic          idle_irq
);
  localparam int unsigned SR_PAD = SR_WIDTH - NF;
  localparam int unsigned DR_PAD = 16 - CW;

  acc_dec_t dec;

  ser_bus_decode u_dec (
    .en   (bus_en),
    .we   (bus_we),
    .addr (bus_addr),
    .size (bus_size),
    .dec  (dec)
  );

  for (genvar i = 0; i < NF; i++) begin : g_flag
    localparam bit TX = TX_MASK[i];
    logic hw_clr;
    if (i == F_TDRE) begin : g_hw
      assign hw_clr = tdre_hw_clr;
    end else begin : g_nohw
      assign hw_clr = 1'b0;
    end
    ser_flag_cell #(.IS_TX(TX), .RST_ONE(RST_VAL[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_pulse[i]),
      .hw_clr_i  (hw_clr),
      .stat_rd_i (dec.stat_rd),
      .dat_rd_i  (dec.dat_rd),
      .dat_wr_i  (dec.dat_wr),
      .word_rd_i (dec.word_rd),
      .flag_o    (flags[i])
    );
  end

  assign bus_rdata = {{SR_PAD{1'b0}}, flags, {DR_PAD{1'b0}}, rx_data_in};

  always_comb begin
    tx_wr_stb  = dec.dat_wr;
    tx_wr_data = '0;
    if (dec.dat_wr) begin
      if (bus_size == SZ_HALF) tx_wr_data = bus_wdata[CW-1:0];
      else                     tx_wr_data = {1'b0, bus_wdata[CW-2:0]};
    end
  end

  assign rx_irq   = rx_irq_en && (flags[F_RDRF] || flags[F_OR]);
  assign idle_irq = idle_irq_en && flags[F_IDLE];
endmodule

// File: rtl/ser_status_arm_chk.sv
module ser_status_arm_chk
  import ser_stat_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [8:0]    set_pulse,
  input logic          tdre_hw_clr,
  input logic          rx_irq_en,
  input logic          idle_irq_en,
  input logic [8:0]    flags,
  input logic          rx_irq,
  input logic          idle_irq
);
  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));

  assert_stat_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !bus_addr[1] && !tdre_hw_clr) |=> (($past(flags) & ~flags) == 9'h0));

  assert_rx_clear_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags[6:0]) & ~flags[6:0])) |-> $past(bus_en && !bus_we));

  assert_tc_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_TC]) |-> $past(bus_en && bus_we && bus_addr[1]));

  assert_tdre_clear_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_TDRE]) |-> $past((bus_en && bus_we) || tdre_hw_clr));

  assert_rx_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en |-> !rx_irq);

  assert_idle_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_irq_en || !flags[F_IDLE]) |-> !idle_irq);
endmodule

bind ser_status_arm ser_status_arm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .set_pulse   (set_pulse),
  .tdre_hw_clr (tdre_hw_clr),
  .rx_irq_en   (rx_irq_en),
  .idle_irq_en (idle_irq_en),
  .flags       (flags),
  .rx_irq      (rx_irq),
  .idle_irq    (idle_irq)
);

// File: tb/sim_ser_status_arm.sv
module sim_ser_status_arm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0, bus_size = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  rx_data_in = 9'h15A;
  logic        tx_wr_stb;
  logic [8:0]  tx_wr_data;
  logic [8:0]  set_pulse = '0;
  logic        tdre_hw_clr = 1'b0;
  logic        rx_irq_en = 1'b0, idle_irq_en = 1'b0;
  logic [8:0]  flags;
  logic        rx_irq, idle_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rd_cap;
  logic        stb_cap;
  logic [8:0]  wd_cap;

  always #10 clk = ~clk;

  ser_status_arm u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic en, input logic we, input logic [1:0] a,
                     input logic [1:0] sz, input logic [15:0] wd, input logic [8:0] setm);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    set_pulse = setm;
    #5;
    rd_cap = bus_rdata; stb_cap = tx_wr_stb; wd_cap = tx_wr_data;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; set_pulse = '0;
  endtask

  task automatic pulse(input logic [8:0] m); acc(0, 0, 0, 0, 0, m); endtask
  task automatic srd(input logic [1:0] a, input logic [1:0] sz); acc(1, 0, a, sz, 0, 0); endtask
  task automatic drd(input logic [1:0] a, input logic [1:0] sz); acc(1, 0, a, sz, 0, 0); endtask
  task automatic dwr(input logic [1:0] a, input logic [1:0] sz, input logic [15:0] d); acc(1, 1, a, sz, d, 0); endtask

  task automatic t_reset;
    chk("R1 flags", flags, 9'h180);
    chk("R1 irqs", {rx_irq, idle_irq}, 0);
  endtask

  task automatic t_set_zero_write;
    pulse(9'h042);
    chk("R2 set", flags, 9'h1C2);
    dwr(0, 1, 16'h0000);
    dwr(1, 0, 16'h0000);
    chk("R2 status write ignored", flags, 9'h1C2);
    chk("R2 no strobe", stb_cap, 0);
  endtask

  task automatic t_rx_clear;
    srd(1, 0);
    chk("R3 armed only", flags, 9'h1C2);
    drd(3, 0);
    chk("R11 rx data", rd_cap[8:0], 9'h15A);
    chk("R3 cleared", flags, 9'h180);
  endtask

  task automatic t_upper_arm;
    pulse(9'h004);
    srd(0, 0);
    drd(2, 1);
    chk("R6 upper byte arms", flags, 9'h180);
  endtask

  task automatic t_tx_clear;
    srd(0, 1);
    drd(3, 0);
    chk("R4 read keeps tx", flags, 9'h180);
    dwr(2, 0, 16'h00FF);
    chk("R4 upper data write", flags, 9'h180);
    chk("R4 no strobe upper", stb_cap, 0);
    dwr(3, 0, 16'h01A5);
    chk("R4 tx cleared", flags, 9'h000);
    chk("R11 strobe", stb_cap, 1);
    chk("R11 byte data", wd_cap, 9'h0A5);
    pulse(9'h180);
    srd(0, 1);
    dwr(2, 1, 16'h01C3);
    chk("R11 half data", wd_cap, 9'h1C3);
    chk("R4 half write clears", flags, 9'h000);
    pulse(9'h180);
  endtask

  task automatic t_late_set;
    pulse(9'h040);
    srd(0, 1);
    pulse(9'h008);
    drd(3, 0);
    chk("R5 late OR survives", flags, 9'h188);
    srd(1, 0);
    drd(3, 0);
    chk("R5 OR cleared later", flags, 9'h180);
  endtask

  task automatic t_word;
    pulse(9'h050);
    acc(1, 0, 0, 2, 0, 0);
    chk("R7 status half", rd_cap[31:16], 32'h01D0);
    chk("R7 data half", rd_cap[15:0], 32'h015A);
    chk("R7 rx cleared tx kept", flags, 9'h180);
  endtask

  task automatic t_race;
    pulse(9'h001);
    srd(1, 0);
    acc(1, 0, 3, 0, 0, 9'h001);
    chk("R8 set wins", flags, 9'h181);
    drd(3, 0);
    chk("R8 disarmed", flags, 9'h181);
    srd(1, 0);
    drd(3, 0);
    chk("R8 fresh clear", flags, 9'h180);
  endtask

  task automatic t_hwclr;
    srd(1, 0);
    @(negedge clk); tdre_hw_clr = 1'b1;
    @(negedge clk); tdre_hw_clr = 1'b0;
    chk("R9 hw clear", flags, 9'h080);
    pulse(9'h100);
    dwr(3, 0, 16'h0011);
    chk("R9 TDRE disarmed, TC cleared", flags, 9'h100);
    pulse(9'h080);
  endtask

  task automatic t_irq;
    pulse(9'h040);
    chk("R10 rx gated off", rx_irq, 0);
    @(negedge clk); rx_irq_en = 1'b1; #1;
    chk("R10 rx on", rx_irq, 1);
    pulse(9'h010);
    chk("R10 idle gated off", idle_irq, 0);
    @(negedge clk); idle_irq_en = 1'b1; #1;
    chk("R10 idle on", idle_irq, 1);
    acc(1, 0, 0, 2, 0, 0);
    chk("R10 rx drops", rx_irq, 0);
    chk("R10 idle drops", idle_irq, 0);
    rx_irq_en = 1'b0; idle_irq_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_set_zero_write;
    t_rx_clear;
    t_upper_arm;
    t_tx_clear;
    t_late_set;
    t_word;
    t_race;
    t_hwclr;
    t_irq;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule